// File: doc/BRIEF.md
# Frame Clock Ratio Detector

This block runs on the bit clock of a serial voice port. It works out how many bit-clock cycles fit in one 8 kHz frame, so that the internal clock generation that follows can be configured from a single code. The bit clock is synchronous to the frame strobe. After reset the block measures the number of bit-clock cycles from one rising edge of the frame strobe to the next. It accepts only a fixed set of frame lengths: 32, 64, 96, 128, 192, 256, 512 or 1024 cycles. These correspond to bit clocks from 256 kHz up to 8.192 MHz.

A length counts only once two consecutive measurements agree. The block then freezes a 3-bit code for it and raises the locked output. The frozen code stays in a private register until the next reset. Nothing outside the block can read or overwrite that register, and later frame-strobe behaviour cannot change it. Three conditions raise the error output and make detection start again: an unsupported length, two measurements that disagree, or a strobe that stops arriving.

Top module: `fsr_ratio_detect`

## Requirements
- R1: While reset is held, and on the first cycle after it, locked_o, err_o and ratio_code_o are all 0.
- R2: The code is assigned in ascending order of frame length: 32→0, 64→1, 96→2, 128→3, 192→4, 256→5, 512→6, 1024→7.
- R3: A frame length is the number of clock cycles between two rising edges of fsync_i. Lock needs two consecutive equal supported lengths, which means three rising edges after reset. After only two rising edges, locked_o is still 0.
- R4: A measured length outside the supported set sets err_o and leaves locked_o at 0. Detection restarts, and a later run of equal supported lengths still locks.
- R5: Two consecutive supported lengths that differ set err_o and leave locked_o at 0. The first length is discarded.
- R6: If more than 1024 cycles pass after a rising edge with no further rising edge, err_o is set. A strobe that never rises after reset raises no error.
- R7: Once locked_o is 1, it stays 1 and ratio_code_o stays unchanged until reset, whatever fsync_i does.
- R8: err_o is 0 whenever locked_o is 1; reaching lock clears an earlier error.
- R9: Only rising edges of fsync_i matter: the width of its high phase has no effect on the detected code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fsync_i | input | 1 | 8 kHz frame strobe, synchronous to clk |
| ratio_code_o | output | 3 | Frozen frame-length code (valid while locked_o is 1) |
| locked_o | output | 1 | High once the frame length has been frozen |
| err_o | output | 1 | High after a failed detection attempt, until lock |

## Verification
The checker watches the same things on every cycle. It confirms the reset values, that lock and the frozen code never change once locked, that error is never high together with lock, and that lock rises only two cycles after a sampled rising edge of the strobe. The code mapping, the three-edge lock latency, the restart after an unsupported or disagreeing length, the timeout error and the indifference to pulse width depend on chosen strobe sequences. Only the bench's scenarios can show those.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int NUM_RATIOS = 8;
    localparam int CODE_W     = $clog2(NUM_RATIOS);
    localparam int MAX_RATIO  = 1024;
    localparam int CNT_W      = $clog2(MAX_RATIO + 2);

    // Frame-length measurement taken at a strobe rising edge
    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] count;
    } period_t;

    // Result of matching a length against the supported set
    typedef struct packed {
        logic              hit;
        logic [CODE_W-1:0] code;
    } ratio_match_t;

    typedef enum logic [1:0] {
        ST_SEEK = 2'd0,
        ST_CAND = 2'd1,
        ST_LOCK = 2'd2
    } lock_state_t;

    // Supported frame length for each code, ascending
    function automatic int ratio_of(input int c);
        case (c)
            0:       return 32;
            1:       return 64;
            2:       return 96;
            3:       return 128;
            4:       return 192;
            5:       return 256;
            6:       return 512;
            default: return 1024;
        endcase
    endfunction

    function automatic ratio_match_t match_count(input logic [CNT_W-1:0] n);
        ratio_match_t m;
        m.hit  = 1'b0;
        m.code = '0;
        for (int i = 0; i < NUM_RATIOS; i++) begin
            if (n == CNT_W'(ratio_of(i))) begin
                m.hit  = 1'b1;
                m.code = CODE_W'(i);
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/fsr_edge_det.sv
module fsr_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic fsync_i,
    output logic rise_o
);
    logic smp_q;
    logic smp_qq;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q  <= 1'b0;
            smp_qq <= 1'b0;
        end else begin
            smp_q  <= fsync_i;
            smp_qq <= smp_q;
        end
    end

    assign rise_o = smp_q & ~smp_qq;
endmodule

// File: rtl/fsr_period_ctr.sv
module fsr_period_ctr
    import fsr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rise_i,
    output period_t meas_o,
    output logic    overrun_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RATIO + 1);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (rise_i) begin
            armed_q <= 1'b1;
            cnt_q   <= CNT_W'(1);
        end else if (armed_q) begin
            if (cnt_q == LIMIT) begin
                armed_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign meas_o.valid = rise_i & armed_q;
    assign meas_o.count = cnt_q;
    assign overrun_o    = armed_q & ~rise_i & (cnt_q == LIMIT);
endmodule

// File: rtl/fsr_lock_fsm.sv
module fsr_lock_fsm
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  period_t           meas_i,
    input  logic              overrun_i,
    output logic [CODE_W-1:0] code_o,
    output logic              locked_o,
    output logic              err_o
);
    lock_state_t       state_q;
    logic [CODE_W-1:0] cand_q;
    logic [CODE_W-1:0] code_q;
    logic              err_q;
    ratio_match_t      match;

    always_comb match = match_count(meas_i.count);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SEEK;
            cand_q  <= '0;
            code_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_SEEK: begin
                    if (overrun_i) begin
                        err_q <= 1'b1;
                    end else if (meas_i.valid) begin
                        if (match.hit) begin
                            cand_q  <= match.code;
                            state_q <= ST_CAND;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_CAND: begin
                    if (overrun_i) begin
                        err_q   <= 1'b1;
                        state_q <= ST_SEEK;
                    end else if (meas_i.valid) begin
                        if (match.hit && (match.code == cand_q)) begin
                            code_q  <= cand_q;
                            err_q   <= 1'b0;
                            state_q <= ST_LOCK;
                        end else begin
                            err_q   <= 1'b1;
                            state_q <= ST_SEEK;
                        end
                    end
                end
                default: begin
                    state_q <= ST_LOCK;
                end
            endcase
        end
    end

    assign code_o   = code_q;
    assign locked_o = (state_q == ST_LOCK);
    assign err_o    = err_q;
endmodule

// File: rtl/fsr_ratio_detect.sv
module fsr_ratio_detect
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fsync_i,
    output logic [CODE_W-1:0] ratio_code_o,
    output logic              locked_o,
    output logic              err_o
);
    logic    rise;
    period_t meas;
    logic    overrun;

    fsr_edge_det edge_i (
        .clk     (clk),
        .rst     (rst),
        .fsync_i (fsync_i),
        .rise_o  (rise)
    );

    fsr_period_ctr ctr_i (
        .clk       (clk),
        .rst       (rst),
        .rise_i    (rise),
        .meas_o    (meas),
        .overrun_o (overrun)
    );

    fsr_lock_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .meas_i    (meas),
        .overrun_i (overrun),
        .code_o    (ratio_code_o),
        .locked_o  (locked_o),
        .err_o     (err_o)
    );
endmodule

// File: rtl/fsr_ratio_detect_chk.sv
module fsr_ratio_detect_chk
    import fsr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fsync_i,
    input logic [CODE_W-1:0] ratio_code_o,
    input logic              locked_o,
    input logic              err_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!locked_o && !err_o && ratio_code_o == '0)); // R1

    AST_LOCK_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> ($past(fsync_i, 2) && !$past(fsync_i, 3))); // R3

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        locked_o |=> locked_o); // R7

    AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        locked_o |=> $stable(ratio_code_o)); // R7

    AST_NO_ERR_WHEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        locked_o |-> !err_o); // R8
endmodule

bind fsr_ratio_detect fsr_ratio_detect_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .fsync_i      (fsync_i),
    .ratio_code_o (ratio_code_o),
    .locked_o     (locked_o),
    .err_o        (err_o)
);

// File: tb/fsr_ratio_detect_tb_top.sv
`timescale 1ns/1ps
module fsr_ratio_detect_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fsync = 1'b0;
    logic [2:0] code;
    logic       locked;
    logic       err;

    int n_checks = 0;
    int n_fail   = 0;

    localparam int NVEC = 8;
    localparam int VEC_LEN  [NVEC] = '{32, 64, 96, 128, 192, 256, 512, 1024};
    localparam int VEC_CODE [NVEC] = '{0, 1, 2, 3, 4, 5, 6, 7};

    always #2 clk = ~clk;

    fsr_ratio_detect dut_i (
        .clk          (clk),
        .rst          (rst),
        .fsync_i      (fsync),
        .ratio_code_o (code),
        .locked_o     (locked),
        .err_o        (err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst   = 1'b1;
        fsync = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic frames(input int len, input int n, input int high);
        for (int f = 0; f < n; f++) begin
            for (int c = 0; c < len; c++) begin
                fsync = (c < high);
                @(negedge clk);
            end
        end
    endtask

    task automatic idle(input int n);
        fsync = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        check("R1 locked in reset", int'(locked), 0);
        check("R1 err in reset", int'(err), 0);
        do_reset();
        check("R1 locked after reset", int'(locked), 0);
        check("R1 err after reset", int'(err), 0);
        check("R1 code after reset", int'(code), 0);

        // R2/R3: table of supported lengths
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            frames(VEC_LEN[v], 2, 1);
            check("R3 not locked after two edges", int'(locked), 0);
            frames(VEC_LEN[v], 1, 1);
            check("R3 locked after three edges", int'(locked), 1);
            check("R2 code", int'(code), VEC_CODE[v]);
            check("R8 err low while locked", int'(err), 0);
        end

        // R4: unsupported length, then recovery; R8 err cleared by lock
        do_reset();
        frames(100, 3, 1);
        check("R4 err on unsupported length", int'(err), 1);
        check("R4 no lock on unsupported length", int'(locked), 0);
        frames(64, 3, 1);
        check("R4 relock after restart", int'(locked), 1);
        check("R4 code after restart", int'(code), 1);
        check("R8 err cleared by lock", int'(err), 0);

        // R5: disagreeing lengths
        do_reset();
        frames(64, 1, 1);
        frames(128, 1, 1);
        frames(64, 1, 1);
        frames(128, 1, 1);
        check("R5 err on mismatch", int'(err), 1);
        check("R5 no lock on mismatch", int'(locked), 0);

        // R6: strobe never rises -> no error; strobe stops -> error
        do_reset();
        idle(1100);
        check("R6 no err without any edge", int'(err), 0);
        frames(64, 1, 1);
        idle(1100);
        check("R6 err on missing edge", int'(err), 1);
        check("R6 no lock on missing edge", int'(locked), 0);

        // R7: frozen after lock
        do_reset();
        frames(256, 3, 1);
        check("R7 locked at 256", int'(locked), 1);
        frames(100, 3, 1);
        frames(32, 3, 7);
        idle(1500);
        check("R7 still locked", int'(locked), 1);
        check("R7 code unchanged", int'(code), 5);
        check("R7 err stays low", int'(err), 0);

        // R9: wide high phase
        do_reset();
        frames(128, 3, 64);
        check("R9 locked with wide pulse", int'(locked), 1);
        check("R9 code with wide pulse", int'(code), 3);

        // R1: reset after lock clears outputs
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 locked cleared by reset", int'(locked), 0);
        check("R1 code cleared by reset", int'(code), 0);

        finish_run();
    end
endmodule